// File: doc/BRIEF.md
# Ping-Pong Windowed Complex FIR Filter

This block is a complex-valued FIR filter that keeps its sample history without a shifting delay line. Two equal sample banks take turns: incoming samples are written at a moving write index into the active bank, while the other bank keeps the samples of the previous pass. The taps read a window made of the incoming sample and the stored samples behind it. When the taps reach back past the start of the active bank, they read the older bank instead. When the write index passes the last slot, the banks exchange roles. Stored samples are never copied from one register to another. Only the indices and the bank-select bit change.

After reset the filter first accepts its tap coefficients, one per handshake, on a separate coefficient stream. Until all taps have arrived it reports busy and refuses samples. After that the coefficients stay fixed, and each accepted sample produces exactly one registered complex output. The output is rounded and saturated back to the sample width. Valid/ready handshakes on the sample input and the result output let a downstream stage stall the filter.

Top module: `pp_fir_cplx`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are 0, `busy` and `coef_ready` are 1, and both sample banks hold zero.
- R2: `busy` stays 1 until exactly TAPS coefficient handshakes have taken place. The first accepted coefficient is h[0], which weights the newest sample, and the last is h[TAPS-1]. After the last one, `busy` and `coef_ready` are 0.
- R3: While `busy` is 1, `in_ready` is 0 and any offered sample is discarded without entering the history.
- R4: For accepted samples x[n], the output is y[n] = sum over k of h[k]*x[n-k], using complex multiplication. Samples from before the first accepted one count as zero. This holds across any number of bank role swaps.
- R5: Coefficients are signed Q1.15. Each accumulated component is rounded by adding 2^14 and shifting right arithmetically by 15 bits.
- R6: A rounded component above 32767 saturates to 32767, and one below -32768 saturates to -32768.
- R7: Every accepted sample produces exactly one output, and `out_valid` rises on the clock edge that accepts the sample.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output data stays stable and `in_ready` is 0.
- R9: Coefficient handshakes offered after loading has finished are ignored: `coef_ready` stays 0 and the outputs keep following the loaded taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid | input | 1 | Coefficient offered |
| coef_ready | output | 1 | Coefficient accepted when high with `coef_valid` |
| coef_re | input | CW | Coefficient real part, Q1.15 |
| coef_im | input | CW | Coefficient imaginary part, Q1.15 |
| busy | output | 1 | High until all taps are loaded |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high with `in_valid` |
| in_re | input | DW | Sample real part |
| in_im | input | DW | Sample imaginary part |
| out_valid | output | 1 | Filtered sample available |
| out_ready | input | 1 | Downstream takes the output |
| out_re | output | DW | Filtered real part |
| out_im | output | DW | Filtered imaginary part |

## Verification
The bench builds the filter with its default parameters: five taps, five-entry banks, 16-bit data and coefficients, and a 40-bit accumulator. At this size, runs of 40 samples force eight bank role swaps, so every window offset is exercised against a plain shift-register reference. Full-scale operands reach both saturation rails, and a one-LSB tap exposes the rounding boundary on either side of zero. Reloading after each reset tests several tap sets, including an impulse response that reads the loaded coefficients back in order.

// File: rtl/pp_fir_cplx.sv
module pp_fir_cplx #(
  parameter int TAPS = 5,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 40,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_valid,
  output logic                 coef_ready,
  input  logic signed [CW-1:0] coef_re,
  input  logic signed [CW-1:0] coef_im,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [IW:0] NT = (IW+1)'(TAPS);
  localparam logic [IW-1:0] LAST = IW'(TAPS - 1);
  localparam logic signed [ACCW-1:0] HALF = {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [ACCW-1:0] SMAX = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SMIN = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] b_re [2][TAPS];
  logic signed [DW-1:0] b_im [2][TAPS];
  logic signed [CW-1:0] h_re [TAPS];
  logic signed [CW-1:0] h_im [TAPS];
  logic [IW:0]   ccnt;
  logic [IW-1:0] widx;
  logic          act;
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic          accept;

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] s;
    s = (a + HALF) >>> FRAC;
    if (s > SMAX)      return SMAX[DW-1:0];
    else if (s < SMIN) return SMIN[DW-1:0];
    else               return s[DW-1:0];
  endfunction

  assign busy       = (ccnt != NT);
  assign coef_ready = busy;
  assign in_ready   = !busy && (!out_valid || out_ready);
  assign accept     = in_valid && in_ready;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < TAPS; k++) begin
      logic [IW:0] pos;
      logic signed [DW-1:0] xr, xi;
      pos = {1'b0, widx} + NT - (IW+1)'(k);
      if (k == 0) begin
        xr = in_re;
        xi = in_im;
      end else if (pos >= NT) begin
        xr = b_re[act][IW'(pos - NT)];
        xi = b_im[act][IW'(pos - NT)];
      end else begin
        xr = b_re[~act][IW'(pos)];
        xi = b_im[~act][IW'(pos)];
      end
      acc_re = acc_re + ACCW'(xr) * ACCW'(h_re[k]) - ACCW'(xi) * ACCW'(h_im[k]);
      acc_im = acc_im + ACCW'(xr) * ACCW'(h_im[k]) + ACCW'(xi) * ACCW'(h_re[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt      <= '0;
      widx      <= '0;
      act       <= 1'b0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < TAPS; i++) begin
          b_re[b][i] <= '0;
          b_im[b][i] <= '0;
        end
      for (int i = 0; i < TAPS; i++) begin
        h_re[i] <= '0;
        h_im[i] <= '0;
      end
    end else begin
      if (coef_valid && coef_ready) begin
        h_re[ccnt[IW-1:0]] <= coef_re;
        h_im[ccnt[IW-1:0]] <= coef_im;
        ccnt <= ccnt + 1'b1;
      end
      if (accept) begin
        b_re[act][widx] <= in_re;
        b_im[act][widx] <= in_im;
        if (widx == LAST) begin
          widx <= '0;
          act  <= ~act;
        end else begin
          widx <= widx + 1'b1;
        end
        out_valid <= 1'b1;
        out_re    <= rnd_sat(acc_re);
        out_im    <= rnd_sat(acc_im);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_no_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(coef_valid));

  p_busy_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy && !coef_ready);

  p_out_follows_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_re) && $stable(out_im));

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_pp_fir_cplx.sv
module test_pp_fir_cplx;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_valid = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [15:0] coef_re = '0, coef_im = '0, in_re = '0, in_im = '0;
  logic coef_ready, busy, in_ready, out_valid;
  logic signed [15:0] out_re, out_im;

  pp_fir_cplx i_pp_fir_cplx (
    .clk(clk), .rst_n(rst_n),
    .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_re(coef_re), .coef_im(coef_im), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint hr[N], hi[N], xr[N], xi[N];
  bit [31:0] st = 32'h1ACE_B00C;

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic longint rnd_sat(longint a);
    longint s;
    s = (a + 16384) >>> 15;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  function automatic longint nxt();
    st = st ^ (st << 13);
    st = st ^ (st >> 17);
    st = st ^ (st << 5);
    return longint'($signed(st[15:0]));
  endfunction

  task automatic do_reset();
    rst_n = 0; coef_valid = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int j = 0; j < N; j++) begin xr[j] = 0; xi[j] = 0; end
    @(negedge clk);
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 busy", longint'(busy), 1);
    chk("R1 coef_ready", longint'(coef_ready), 1);
    chk("R1 in_ready", longint'(in_ready), 0);
  endtask

  task automatic load(bit probe);
    if (probe) begin
      in_valid = 1; in_re = 16'sd7777; in_im = -16'sd555;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R3 in_ready while busy", longint'(in_ready), 0);
      end
      in_valid = 0;
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk("R2 busy during load", longint'(busy), 1);
      coef_valid = 1; coef_re = 16'(hr[k]); coef_im = 16'(hi[k]);
      @(posedge clk);
      #1 coef_valid = 0;
    end
    @(negedge clk);
    chk("R2 busy after load", longint'(busy), 0);
    chk("R2 coef_ready after load", longint'(coef_ready), 0);
    chk("R3 no output from discarded sample", longint'(out_valid), 0);
  endtask

  task automatic push(string req, longint sr, longint si, int stall, bit junk);
    longint er, ei;
    for (int j = N - 1; j > 0; j--) begin xr[j] = xr[j-1]; xi[j] = xi[j-1]; end
    xr[0] = sr; xi[0] = si;
    er = 0; ei = 0;
    for (int k = 0; k < N; k++) begin
      er += hr[k] * xr[k] - hi[k] * xi[k];
      ei += hr[k] * xi[k] + hi[k] * xr[k];
    end
    er = rnd_sat(er); ei = rnd_sat(ei);
    @(negedge clk);
    in_valid = 1; in_re = 16'(sr); in_im = 16'(si);
    if (junk) begin coef_valid = 1; coef_re = 16'sh4321; coef_im = -16'sd9000; end
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R8 held valid", longint'(out_valid), 1);
      chk("R8 held re", longint'(out_re), er);
      chk("R8 held im", longint'(out_im), ei);
      chk("R8 in_ready low in stall", longint'(in_ready), 0);
    end
    @(negedge clk);
    chk("R7 out_valid", longint'(out_valid), 1);
    chk({req, " re"}, longint'(out_re), er);
    chk({req, " im"}, longint'(out_im), ei);
    if (junk) chk("R9 coef_ready", longint'(coef_ready), 0);
    out_ready = 1;
    @(posedge clk);
    #1 out_ready = 0; coef_valid = 0;
    @(negedge clk);
    chk("R7 single output", longint'(out_valid), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R7 watchdog expired");
    summary();
  end

  initial begin
    hr = '{9830, -6554, 3277, 16384, -1638};
    hi = '{0, 2000, -3000, 500, -100};
    do_reset();
    load(1);
    for (int i = 0; i < 8; i++) push("R4 impulse", (i == 0) ? 32767 : 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) push("R4 stream", nxt(), nxt(), i % 3, 0);

    for (int k = 0; k < N; k++) begin hr[k] = nxt() / 2; hi[k] = nxt() / 2; end
    do_reset();
    load(0);
    for (int i = 0; i < 40; i++) push("R9 after junk coef", nxt(), nxt(), i % 2, 1);

    for (int k = 0; k < N; k++) begin hr[k] = 32767; hi[k] = 0; end
    do_reset();
    load(0);
    for (int i = 0; i < 12; i++) push("R6 positive rail", 32767, 32767, 0, 0);
    for (int i = 0; i < 12; i++) push("R6 negative rail", -32768, -32768, 0, 0);

    for (int k = 0; k < N; k++) begin hr[k] = 0; hi[k] = 0; end
    hr[0] = 1;
    do_reset();
    load(0);
    push("R5 half up", 16384, -16384, 0, 0);
    push("R5 below half", 16383, -16385, 0, 0);
    push("R5 neg extreme", -32768, 32767, 1, 0);
    push("R5 tiny", 1, -1, 0, 0);
    summary();
  end
endmodule